// File: doc/BRIEF.md
# External Interrupt Request Conditioner

This block sits between four external interrupt request pins and the chip's interrupt priority encoder. Each pin is brought into the clock domain through a two-flop synchronizer. It is then interpreted according to its own programmable sense type: active-high level, rising edge, falling edge or active-low level. The result is gated into one request line per pin. Edge-sensed pins record each qualifying edge in a sticky latch, and software releases that latch by writing a one-shot acknowledge bit.

All configuration sits in a single 32-bit control word on a simple register bus. The word has byte write strobes and a combinational read. The word holds a sense code per pin, an enable per pin, a master enable that gates every pin, write-one-to-clear acknowledge bits, and a routing select for the critical-level request. Because the strobes are per byte, a driver can change enables or acknowledge edges without rewriting the sense codes. The block has no data stream, so all of its pins are plain control and status signals.

Top module: `ext_irq_cond`

## Requirements
- R1: After reset, the read value is 0, every request output is 0 and the critical routing output is 0.
- R2: The sense code of pin n is held in control bits [23-2n:22-2n], which live in byte 2. The codes are 0 for active-high level, 1 for rising edge, 2 for falling edge and 3 for active-low level. The field reads back as written.
- R3: For a level code, the request of pin n follows the pin's level (code 0) or its inverse (code 3). The request changes two clock edges after the pin changes.
- R4: For an edge code, a synchronized rising edge (code 1) or falling edge (code 2) sets the pin's latch. The request is then raised three clock edges after the pin changes, and it stays high until the latch is cleared.
- R5: Control bit 11-n (byte 1) enables pin n, with 1 meaning enabled. A disabled pin drives no request, but its latch still records edges, and those edges show up when the pin is enabled.
- R6: Control bit 12 is the master enable. While it is 0, every request output is 0.
- R7: Writing 1 to control bit 27-n (byte 3) clears the latch of pin n. These bits always read as 0. If an edge arrives in the same cycle as the clear, the edge wins and the latch stays set.
- R8: A write changes only the bytes whose strobe reg_be[k] is 1. Bits outside 27:24, 23:16, 12:8 and 0 are not stored and read as 0.
- R9: Control bit 0 (byte 0) drives the crit_route output and reads back as written.
- R10: While a pin has a level code, its latch is held clear. An edge recorded before a switch to level sense therefore does not survive a switch back to edge sense.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 4 | Raw external request pins, asynchronous |
| reg_we | input | 1 | Control word write strobe |
| reg_be | input | 4 | Byte write enables for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Control word read value, combinational |
| irq_req | output | 4 | Conditioned request per pin, to the priority encoder |
| crit_route | output | 1 | Routing select for the critical-level request |

## Verification
The assertions assume that reset is held low for at least one clock edge and that every input carries a known value. They also assume that the register strobes change only away from the rising edge, while the pins themselves may change at any time. The stimulus drives every input a few nanoseconds after a rising edge, from known values, and holds reset over several edges at the start. Pin activity includes pulses shorter than the synchronizer delay and edges that coincide with acknowledge writes. It also includes sense changes made while a latch is set and partial-byte writes, so that every ordering the latch can see is reached.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SNS_LVL_HI = 2'd0,
    SNS_RISE   = 2'd1,
    SNS_FALL   = 2'd2,
    SNS_LVL_LO = 2'd3
  } sense_e;

  localparam int WORD_W     = 32;
  localparam int SENSE_TOP  = 23;
  localparam int EN_TOP     = 11;
  localparam int CLR_TOP    = 27;
  localparam int MASTER_BIT = 12;
  localparam int ROUTE_BIT  = 0;
endpackage

// File: rtl/ext_irq_ctrl_reg.sv
module ext_irq_ctrl_reg
  import ext_irq_pkg::*;
#(
  parameter int NPIN = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [WORD_W/8-1:0]    be,
  input  logic [WORD_W-1:0]      wdata,
  output logic [WORD_W-1:0]      rdata,
  output sense_e                 sense [NPIN],
  output logic [NPIN-1:0]        en,
  output logic                   master,
  output logic                   route,
  output logic [NPIN-1:0]        clr
);
  localparam int MB = MASTER_BIT / 8;
  localparam int RB = ROUTE_BIT / 8;

  sense_e sense_q [NPIN];
  logic [NPIN-1:0] en_q;
  logic master_q, route_q;

  for (genvar n = 0; n < NPIN; n++) begin : g_pin
    localparam int SLO = SENSE_TOP - 1 - 2 * n;
    localparam int SB  = SLO / 8;
    localparam int EB  = (EN_TOP - n) / 8;
    localparam int CB  = (CLR_TOP - n) / 8;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sense_q[n] <= SNS_LVL_HI;
        en_q[n]    <= 1'b0;
      end else if (we) begin
        if (be[SB]) sense_q[n] <= sense_e'(wdata[SLO +: 2]);
        if (be[EB]) en_q[n]    <= wdata[EN_TOP - n];
      end
    end

    assign clr[n]   = we && be[CB] && wdata[CLR_TOP - n];
    assign sense[n] = sense_q[n];

    // R8: sense fields change only when their byte is written
    a_r8_sense_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && be[SB]) |=> $stable(sense_q[n]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      route_q  <= 1'b0;
    end else if (we) begin
      if (be[MB]) master_q <= wdata[MASTER_BIT];
      if (be[RB]) route_q  <= wdata[ROUTE_BIT];
    end
  end

  always_comb begin
    rdata = '0;
    for (int n = 0; n < NPIN; n++) begin
      rdata[SENSE_TOP - 2*n -: 2] = sense_q[n];
      rdata[EN_TOP - n]           = en_q[n];
    end
    rdata[MASTER_BIT] = master_q;
    rdata[ROUTE_BIT]  = route_q;
  end

  assign en     = en_q;
  assign master = master_q;
  assign route  = route_q;
endmodule

// File: rtl/ext_irq_pin_cond.sv
module ext_irq_pin_cond
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pin,
  input  sense_e sense,
  input  logic   en,
  input  logic   master,
  input  logic   clr,
  output logic   req
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q, latch_q, lvl, edge_hit, is_level, active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign lvl      = sync_q[SYNC_STAGES-1];
  assign is_level = (sense == SNS_LVL_HI) || (sense == SNS_LVL_LO);
  assign edge_hit = ((sense == SNS_RISE) && lvl && !prev_q) ||
                    ((sense == SNS_FALL) && !lvl && prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= 1'b0;
    else if (is_level) latch_q <= 1'b0;
    else if (edge_hit) latch_q <= 1'b1;
    else if (clr)      latch_q <= 1'b0;
  end

  always_comb begin
    unique case (sense)
      SNS_LVL_HI: active = lvl;
      SNS_LVL_LO: active = !lvl;
      default:    active = latch_q;
    endcase
  end

  assign req = active && en && master;

  // R4: a set latch holds while edge-sensed and not acknowledged
  a_r4_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !is_level && !clr) |=> latch_q);
  // R7: acknowledge without a fresh edge empties the latch
  a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !edge_hit) |=> !latch_q);
  // R7: an edge coinciding with acknowledge wins
  a_r7_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> latch_q);
  // R10: level sense keeps the latch empty
  a_r10_level_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
    is_level |=> !latch_q);
endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
  import ext_irq_pkg::*;
#(
  parameter int NPIN = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  irq_pin,
  input  logic        reg_we,
  input  logic [3:0]  reg_be,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [3:0]  irq_req,
  output logic        crit_route
);
  sense_e          sense [NPIN];
  logic [NPIN-1:0] en, clr;
  logic            master;

  ext_irq_ctrl_reg #(.NPIN(NPIN)) u_reg (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .be(reg_be), .wdata(reg_wdata),
    .rdata(reg_rdata), .sense(sense), .en(en), .master(master),
    .route(crit_route), .clr(clr)
  );

  for (genvar n = 0; n < NPIN; n++) begin : g_cond
    ext_irq_pin_cond #(.SYNC_STAGES(2)) u_pin (
      .clk(clk), .rst_n(rst_n), .pin(irq_pin[n]), .sense(sense[n]),
      .en(en[n]), .master(master), .clr(clr[n]), .req(irq_req[n])
    );
  end

  // R6: master enable off silences every request
  a_r6_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> (irq_req == '0));
  // R5: a disabled pin never requests
  a_r5_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~en) == '0);
  // R7: acknowledge bits never read back
  a_r7_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[27:24] == 4'h0);
endmodule

// File: tb/ext_irq_cond_test.sv
`timescale 1ns/1ps
module ext_irq_cond_test;
  logic clk = 0, rst_n = 0;
  logic [3:0] irq_pin = 0;
  logic reg_we = 0;
  logic [3:0] reg_be = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [3:0] irq_req;
  logic crit_route;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ext_irq_cond uut (.*);

  // behavioural reference: pin history queue and plain integer state
  logic [3:0] hist[$] = '{4'h0, 4'h0, 4'h0};
  int m_sense[4];
  bit m_en[4], m_lat[4];
  bit m_master, m_route;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{4'h0, 4'h0, 4'h0};
      for (int n = 0; n < 4; n++) begin m_sense[n] = 0; m_en[n] = 0; m_lat[n] = 0; end
      m_master = 0; m_route = 0;
    end else begin
      for (int n = 0; n < 4; n++) begin
        bit s2, s3, hit, ack;
        s2 = hist[1][n]; s3 = hist[2][n];
        hit = (m_sense[n] == 1 && s2 && !s3) || (m_sense[n] == 2 && !s2 && s3);
        ack = reg_we && reg_be[3] && reg_wdata[27-n];
        if (m_sense[n] == 0 || m_sense[n] == 3) m_lat[n] = 0;
        else if (hit) m_lat[n] = 1;
        else if (ack) m_lat[n] = 0;
        if (reg_we && reg_be[2]) m_sense[n] = (reg_wdata >> (22 - 2*n)) & 3;
        if (reg_we && reg_be[1]) m_en[n] = reg_wdata[11-n];
      end
      if (reg_we && reg_be[1]) m_master = reg_wdata[12];
      if (reg_we && reg_be[0]) m_route = reg_wdata[0];
      hist.push_front(irq_pin);
      void'(hist.pop_back());
    end
  end

  function automatic logic [3:0] exp_req();
    logic [3:0] r;
    for (int n = 0; n < 4; n++) begin
      bit s2, act;
      s2 = hist[1][n];
      act = (m_sense[n] == 0) ? s2 : (m_sense[n] == 3) ? !s2 : m_lat[n];
      r[n] = act && m_en[n] && m_master;
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_rdata();
    logic [31:0] w = 0;
    for (int n = 0; n < 4; n++) begin
      w[23-2*n -: 2] = m_sense[n][1:0];
      w[11-n] = m_en[n];
    end
    w[12] = m_master; w[0] = m_route;
    return w;
  endfunction

  function automatic string req_tag();
    if (!m_master) return "R6";
    for (int n = 0; n < 4; n++) if (!m_en[n]) return "R5";
    return "R3/R4";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2", reg_rdata, exp_rdata());
    chk(req_tag(), {28'h0, irq_req}, {28'h0, exp_req()});
    chk("R9", {31'h0, crit_route}, {31'h0, m_route});
  endtask

  // one cycle: edge, compare after it, leave inputs for caller mid-cycle
  task automatic step();
    @(posedge clk); #2; compare_all(); #2;
    reg_we = 0;
  endtask

  task automatic wr(logic [3:0] be, logic [31:0] d);
    reg_we = 1; reg_be = be; reg_wdata = d;
    step();
  endtask

  task automatic steps(int k);
    for (int i = 0; i < k; i++) step();
  endtask

  initial begin
    #2_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #4;
    chk("R1", reg_rdata, 32'h0);
    chk("R1", {28'h0, irq_req}, 32'h0);
    chk("R1", {31'h0, crit_route}, 32'h0);
    rst_n = 1;
    steps(2);

    // R2: codes 1,2,3,0 on pins 0..3 land in bits 23:16 = 0x6C
    wr(4'b0100, 32'h006C_0000);
    chk("R2", reg_rdata, 32'h006C_0000);
    // enable all, master on, route on
    wr(4'b0011, 32'h0000_1F01);
    chk("R9", {31'h0, crit_route}, 32'h1);
    // R8: byte1/byte0 write with junk in byte 2 leaves sense intact
    wr(4'b1011, 32'h00FF_1F01);
    chk("R8", reg_rdata, 32'h006C_1F01);
    chk("R8", {28'h0, irq_req}, {28'h0, exp_req()});

    // R4: rising edge on pin 0 latched three edges after the change
    irq_pin[0] = 1; steps(2);
    chk("R4", {31'h0, irq_req[0]}, 32'h0);
    step();
    chk("R4", {31'h0, irq_req[0]}, 32'h1);
    irq_pin[0] = 0; steps(4);
    chk("R4", {31'h0, irq_req[0]}, 32'h1);
    // R7: acknowledge clears, bits read 0
    wr(4'b1000, 32'h0800_0000);
    chk("R7", {31'h0, irq_req[0]}, 32'h0);
    chk("R7", {28'h0, reg_rdata[27:24]}, 32'h0);

    // R3: pin 2 active-low level, pin 3 active-high level
    irq_pin[3] = 1; step();
    chk("R3", {31'h0, irq_req[3]}, 32'h0);
    step();
    chk("R3", {31'h0, irq_req[3]}, 32'h1);
    chk("R3", {31'h0, irq_req[2]}, 32'h1);
    irq_pin[2] = 1; steps(2);
    chk("R3", {31'h0, irq_req[2]}, 32'h0);

    // R5: disabled pin 0 still latches an edge
    wr(4'b0010, 32'h0000_1700);
    irq_pin[0] = 1; steps(4);
    chk("R5", {31'h0, irq_req[0]}, 32'h0);
    wr(4'b0010, 32'h0000_1F00);
    chk("R5", {31'h0, irq_req[0]}, 32'h1);

    // R6: master off
    wr(4'b0010, 32'h0000_0F00);
    chk("R6", {28'h0, irq_req}, 32'h0);
    wr(4'b0010, 32'h0000_1F00);

    // R10: switch pin 0 to level and back drops the latch
    wr(4'b0100, 32'h002C_0000);
    irq_pin[0] = 1; step();
    wr(4'b0100, 32'h006C_0000);
    chk("R10", {31'h0, irq_req[0]}, 32'h0);

    // R7: pin 1 falling edge coinciding with acknowledge: edge wins
    irq_pin[1] = 1; steps(4);
    irq_pin[1] = 0; steps(2);
    wr(4'b1000, 32'h0400_0000);
    chk("R7", {31'h0, irq_req[1]}, 32'h1);

    // mixed random traffic compared every cycle
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) == 0) irq_pin = 4'($urandom);
      if ($urandom_range(0, 7) == 0) begin
        reg_we = 1; reg_be = 4'($urandom);
        reg_wdata = $urandom | 32'h0000_1000;
      end
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule